// File: doc/BRIEF.md
# General-Purpose Timer with Compare and PWM Output

This block is a 32-bit up-counter with a small synchronous register bus. Software sets a reload value, picks whether the counter reloads or halts after it wraps, and can slow the count with a power-of-two divider. A compare register raises a flag when the count reaches it. Software can read or overwrite the live count at any time. A write to a dedicated strobe address copies the reload value into the counter.

Wrap and compare events set sticky status bits. Software clears each bit by writing a one to it, and an enable mask decides which bits drive the interrupt line. The same events can drive a waveform pin. Its idle level, whether it toggles or gives a one-cycle pulse, and which events fire it all come from fields of the control word. The capture edge and capture mode fields are held only so they read back.

Top module: `gp_timer`

## Requirements
- R1: After reset every register reads 0, `pwm_o` is 0 and `irq_o` is 0.
- R2: A write of any data to offset 0x30 copies the load register (0x2C) into the counter (0x28) at that clock edge.
- R3: A write to offset 0x28 sets the counter to the written value, and a read of 0x28 returns the live count.
- R4: While control bit 0 (run) is 1 and bit 5 (divider enable) is 0, the counter increments at every clock edge, starting with the first edge after the write that sets run.
- R5: With control bit 5 set and bits 4:2 equal to N, the counter increments once every 2^(N+1) clocks.
- R6: When the counter wraps from 0xFFFFFFFF and control bit 1 (auto-reload) is 0, the counter becomes 0, status bit 1 is set and control bit 0 is cleared.
- R7: When the counter wraps and control bit 1 is 1, the counter takes the load value, status bit 1 is set and counting goes on.
- R8: When control bit 6 (compare enable) is 1 and the counter steps onto the value at 0x38, status bit 0 is set. When bit 6 is 0, no compare flag is raised.
- R9: Status (0x18) bits are cleared by writing 1 to them. Writing 0 to a bit leaves it unchanged.
- R10: `irq_o` is 1 exactly when some status bit and the same bit of the enable register (0x1C) are both 1.
- R11: Control bits 11:10 select what fires the pin: 0 nothing, 1 wrap only, 2 wrap or compare, 3 nothing.
- R12: Control bit 7 is the pin's idle level. With control bit 12 set, each firing inverts the pin. With bit 12 clear, each firing drives the opposite of the idle level for exactly one clock.
- R13: The control register reads back bits 14:0 as written, including capture edge bits 9:8, mode bit 13 and direction bit 14. The wake mask at 0x20 is stored and reads back. Offsets 0x30, 0x34 and 0x3C always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |
| pwm_o | output | 1 | Waveform output pin |

## Verification
The bench counts the exact number of clock edges from the write that sets run to the write that clears it. A counter that missed the first edge, or divided by 2^N instead of 2^(N+1), would read back off by one or more. It drives the counter up to the wrap with auto-reload off and then on. A design that kept running, wrapped to the load value without auto-reload, or lost the overflow bit would show up in the counter, control and status readbacks.

The pin is sampled cycle by cycle around each firing. A pulse held for two cycles, a toggle that skipped a wrap, or a compare firing under the wrap-only setting would each give a wrong level. Writes of 0 to status bits, and interrupt masks that do not match the pending bits, check that clearing and masking touch only the intended bits.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CTRL_W = 15;
  localparam int unsigned STAT_W = 3;

  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_WAKE  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_TRIG  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_MATCH = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_CAPT  = 8'h3C;

  // control word bit positions
  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_AR   = 1;
  localparam int unsigned CB_DIV  = 2;
  localparam int unsigned CB_DEN  = 5;
  localparam int unsigned CB_CE   = 6;
  localparam int unsigned CB_DEF  = 7;
  localparam int unsigned CB_FIRE = 10;
  localparam int unsigned CB_TOG  = 12;

  localparam int unsigned SB_MATCH = 0;
  localparam int unsigned SB_OVF   = 1;

  typedef enum logic [1:0] {
    FIRE_NONE = 2'd0,
    FIRE_OVF  = 2'd1,
    FIRE_BOTH = 2'd2,
    FIRE_RSVD = 2'd3
  } fire_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned SEL_W   = 3,
  parameter bit          HAS_DIV = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             div_en_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             tick_o
);
  localparam int unsigned PS_W = 1 << SEL_W;

  generate
    if (HAS_DIV) begin : g_div
      logic [PS_W-1:0] ps_q;
      logic [PS_W-1:0] lim;
      logic            wrap;

      assign lim  = (PS_W'(2) << div_sel_i) - PS_W'(1);
      assign wrap = ps_q >= lim;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    ps_q <= '0;
        else if (!run_i || !div_en_i)   ps_q <= '0;
        else if (wrap)                  ps_q <= '0;
        else                            ps_q <= ps_q + PS_W'(1);
      end

      assign tick_o = run_i && (!div_en_i || wrap);
    end else begin : g_nodiv
      logic unused_sel;
      assign unused_sel = div_en_i ^ (^div_sel_i) ^ clk_i ^ rst_ni;
      assign tick_o = run_i;
    end
  endgenerate
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ar_i,
  input  logic             ce_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic             trig_wr_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_evt_o,
  output logic             match_evt_o,
  output logic             stop_req_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_step;
  logic             at_max, sw_wr, adv;

  assign at_max   = cnt_q == CNT_MAX;
  assign sw_wr    = trig_wr_i || cnt_wr_i;
  assign adv      = tick_i && !sw_wr;
  assign cnt_step = at_max ? (ar_i ? load_i : '0) : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (trig_wr_i) cnt_q <= load_i;
    else if (cnt_wr_i)  cnt_q <= wdata_i;
    else if (adv)       cnt_q <= cnt_step;
  end

  assign cnt_o       = cnt_q;
  assign ovf_evt_o   = adv && at_max;
  assign match_evt_o = adv && ce_i && (cnt_step == match_i);
  assign stop_req_o  = ovf_evt_o && !ar_i;
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm
  import tmr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      def_i,
  input  logic      tog_mode_i,
  input  fire_sel_e fire_sel_i,
  input  logic      ovf_evt_i,
  input  logic      match_evt_i,
  output logic      fire_o,
  output logic      pwm_o
);
  logic tog_q, pulse_q;

  always_comb begin
    unique case (fire_sel_i)
      FIRE_OVF:  fire_o = ovf_evt_i;
      FIRE_BOTH: fire_o = ovf_evt_i || match_evt_i;
      default:   fire_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (fire_sel_i == FIRE_NONE)  tog_q <= 1'b0;
      else if (fire_o && tog_mode_i) tog_q <= ~tog_q;
      pulse_q <= fire_o && !tog_mode_i;
    end
  end

  assign pwm_o = def_i ^ (tog_mode_i ? tog_q : pulse_q);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              ovf_evt_i,
  input  logic              match_evt_i,
  input  logic              stop_req_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] match_o,
  output logic              trig_wr_o,
  output logic              cnt_wr_o,
  output logic              irq_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [STAT_W-1:0] stat_q, stat_set, stat_clr, ien_q, wake_q;
  logic [DATA_W-1:0] load_q, match_q;
  logic              wr;

  assign wr = bus_sel_i && bus_we_i;

  always_comb begin
    stat_set = '0;
    stat_set[SB_MATCH] = match_evt_i;
    stat_set[SB_OVF]   = ovf_evt_i;
    stat_clr = (wr && bus_addr_i == OFS_STAT) ? bus_wdata_i[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      stat_q  <= '0;
      ien_q   <= '0;
      wake_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | stat_set;
      if (wr && bus_addr_i == OFS_CTRL) ctrl_q <= bus_wdata_i[CTRL_W-1:0];
      else if (stop_req_i)              ctrl_q[CB_RUN] <= 1'b0;
      if (wr && bus_addr_i == OFS_IEN)   ien_q   <= bus_wdata_i[STAT_W-1:0];
      if (wr && bus_addr_i == OFS_WAKE)  wake_q  <= bus_wdata_i[STAT_W-1:0];
      if (wr && bus_addr_i == OFS_LOAD)  load_q  <= bus_wdata_i;
      if (wr && bus_addr_i == OFS_MATCH) match_q <= bus_wdata_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      unique case (bus_addr_i)
        OFS_STAT:  bus_rdata_o = DATA_W'(stat_q);
        OFS_IEN:   bus_rdata_o = DATA_W'(ien_q);
        OFS_WAKE:  bus_rdata_o = DATA_W'(wake_q);
        OFS_CTRL:  bus_rdata_o = DATA_W'(ctrl_q);
        OFS_CNT:   bus_rdata_o = cnt_i;
        OFS_LOAD:  bus_rdata_o = load_q;
        OFS_MATCH: bus_rdata_o = match_q;
        default:   bus_rdata_o = '0; // trigger, pending, capture, unmapped
      endcase
    end
  end

  assign ctrl_o    = ctrl_q;
  assign stat_o    = stat_q;
  assign load_o    = load_q;
  assign match_o   = match_q;
  assign trig_wr_o = wr && bus_addr_i == OFS_TRIG;
  assign cnt_wr_o  = wr && bus_addr_i == OFS_CNT;
  assign irq_o     = |(stat_q & ien_q);
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import tmr_pkg::*;
#(
  parameter bit HAS_DIV = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              pwm_o
);
  localparam int unsigned SEL_W = 3;

  logic [CTRL_W-1:0] ctrl;
  logic [STAT_W-1:0] stat;
  logic [DATA_W-1:0] load, match, cnt;
  logic              trig_wr, cnt_wr, tick, ovf_evt, match_evt, stop_req, fire;
  fire_sel_e         fire_sel;

  assign fire_sel = fire_sel_e'(ctrl[CB_FIRE +: 2]);

  tmr_regs u_regs (
    .clk_i, .rst_ni, .bus_sel_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .cnt_i(cnt), .ovf_evt_i(ovf_evt), .match_evt_i(match_evt), .stop_req_i(stop_req),
    .ctrl_o(ctrl), .stat_o(stat), .load_o(load), .match_o(match),
    .trig_wr_o(trig_wr), .cnt_wr_o(cnt_wr), .irq_o
  );

  tmr_prescale #(.SEL_W(SEL_W), .HAS_DIV(HAS_DIV)) u_ps (
    .clk_i, .rst_ni, .run_i(ctrl[CB_RUN]), .div_en_i(ctrl[CB_DEN]),
    .div_sel_i(ctrl[CB_DIV +: SEL_W]), .tick_o(tick)
  );

  tmr_core #(.CNT_W(DATA_W)) u_core (
    .clk_i, .rst_ni, .tick_i(tick), .ar_i(ctrl[CB_AR]), .ce_i(ctrl[CB_CE]),
    .load_i(load), .match_i(match), .trig_wr_i(trig_wr), .cnt_wr_i(cnt_wr),
    .wdata_i(bus_wdata_i), .cnt_o(cnt), .ovf_evt_o(ovf_evt),
    .match_evt_o(match_evt), .stop_req_o(stop_req)
  );

  tmr_pwm u_pwm (
    .clk_i, .rst_ni, .def_i(ctrl[CB_DEF]), .tog_mode_i(ctrl[CB_TOG]),
    .fire_sel_i(fire_sel), .ovf_evt_i(ovf_evt), .match_evt_i(match_evt),
    .fire_o(fire), .pwm_o
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [CTRL_W-1:0] ctrl,
  input logic [STAT_W-1:0] stat,
  input logic [DATA_W-1:0] cnt,
  input logic              tick,
  input logic              ovf_evt,
  input logic              fire,
  input logic              pwm_o
);
  logic sw_cnt;
  assign sw_cnt = bus_sel_i && bus_we_i && (bus_addr_i == OFS_CNT || bus_addr_i == OFS_TRIG);

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !sw_cnt && cnt != '1) |=> cnt == $past(cnt) + DATA_W'(1));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !sw_cnt) |=> $stable(cnt));

  p_tick_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> ctrl[CB_RUN]);

  p_ovf_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> stat[SB_OVF]);

  p_ovf_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_evt && !ctrl[CB_AR] && !(bus_sel_i && bus_we_i && bus_addr_i == OFS_CTRL))
    |=> !ctrl[CB_RUN]);

  p_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl[CB_TOG] && pwm_o != ctrl[CB_DEF] && !fire && !(bus_sel_i && bus_we_i))
    |=> pwm_o == ctrl[CB_DEF]);

  p_pend_zero_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_we_i && bus_addr_i == OFS_PEND) |-> bus_rdata_o == '0);
endmodule

bind gp_timer tmr_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o), .ctrl(ctrl), .stat(stat),
  .cnt(cnt), .tick(tick), .ovf_evt(ovf_evt), .fire(fire), .pwm_o(pwm_o)
);

// File: tb/tb_gp_timer.sv
`timescale 1ns/1ps
module tb_gp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, pwm;
  int          checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  gp_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .pwm_o(pwm)
  );

  // monitor: compares each read against the queued expectation
  always @(negedge clk) begin
    if (sel && !we && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", t, addr, rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    sel = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); #1;
    sel = 1'b0;
  endtask

  task automatic pin(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s pin actual=%b expected=%b", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    rd(8'h24, 32'h0, "R1 ctrl"); rd(8'h18, 32'h0, "R1 status");
    rd(8'h28, 32'h0, "R1 counter"); rd(8'h2C, 32'h0, "R1 load");
    @(negedge clk); pin(pwm, 1'b0, "R1 pwm"); pin(irq, 1'b0, "R1 irq");
    @(posedge clk); #1;

    // R2 trigger load, R3 direct write
    wr(8'h2C, 32'h100); wr(8'h30, 32'hDEAD_BEEF);
    rd(8'h28, 32'h100, "R2 trigger load");
    wr(8'h28, 32'h1234_5678); rd(8'h28, 32'h1234_5678, "R3 counter write");

    // R4 one per clock: 10 edges from start to stop
    wr(8'h28, 32'd10); wr(8'h24, 32'h1); idle(9); wr(8'h24, 32'h0);
    rd(8'h28, 32'd20, "R4 count per clock");

    // R5 divider N=1 and N=0
    wr(8'h28, 32'd0); wr(8'h24, 32'h25); idle(11); wr(8'h24, 32'h0);
    rd(8'h28, 32'd3, "R5 divide by 4");
    wr(8'h28, 32'd0); wr(8'h24, 32'h21); idle(9); wr(8'h24, 32'h0);
    rd(8'h28, 32'd5, "R5 divide by 2");

    // R6 wrap without auto-reload
    wr(8'h1C, 32'h2); wr(8'h28, 32'hFFFF_FFFE); wr(8'h24, 32'h1); idle(4);
    rd(8'h28, 32'h0, "R6 counter wraps to 0"); rd(8'h24, 32'h0, "R6 run cleared");
    rd(8'h18, 32'h2, "R6 overflow flag");
    @(negedge clk); pin(irq, 1'b1, "R10 irq on enabled overflow"); @(posedge clk); #1;
    // R9 zero bits ignored, one bits clear
    wr(8'h18, 32'h1); rd(8'h18, 32'h2, "R9 write of 0 keeps bit");
    wr(8'h18, 32'h2); rd(8'h18, 32'h0, "R9 write 1 clears");
    @(negedge clk); pin(irq, 1'b0, "R10 irq drops"); @(posedge clk); #1;

    // R7 wrap with auto-reload
    wr(8'h2C, 32'h55); wr(8'h28, 32'hFFFF_FFFF); wr(8'h24, 32'h3); idle(3); wr(8'h24, 32'h2);
    rd(8'h28, 32'h58, "R7 reload then count"); rd(8'h18, 32'h2, "R7 overflow flag");
    wr(8'h18, 32'h7);

    // R8 compare enabled
    wr(8'h38, 32'h30); wr(8'h28, 32'h2A); wr(8'h24, 32'h41); idle(10); wr(8'h24, 32'h0);
    rd(8'h28, 32'h35, "R8 counter"); rd(8'h18, 32'h1, "R8 match flag");
    @(negedge clk); pin(irq, 1'b0, "R10 match masked"); @(posedge clk); #1;
    wr(8'h1C, 32'h1);
    @(negedge clk); pin(irq, 1'b1, "R10 match enabled"); @(posedge clk); #1;
    wr(8'h18, 32'h7);
    // R8 compare disabled
    wr(8'h28, 32'h2E); wr(8'h24, 32'h1); idle(5); wr(8'h24, 32'h0);
    rd(8'h28, 32'h34, "R8 passes match"); rd(8'h18, 32'h0, "R8 no flag when disabled");

    // R12 toggle on wrap (R11 field 1)
    wr(8'h2C, 32'hFFFF_FFFD); wr(8'h28, 32'hFFFF_FFFD); wr(8'h24, 32'h1403);
    repeat (2) @(posedge clk); @(negedge clk); pin(pwm, 1'b0, "R12 toggle before wrap");
    @(posedge clk); @(negedge clk); pin(pwm, 1'b1, "R12 toggle at first wrap");
    repeat (3) @(posedge clk); @(negedge clk); pin(pwm, 1'b0, "R12 toggle at second wrap");
    @(posedge clk); #1;
    wr(8'h24, 32'h0);
    @(negedge clk); pin(pwm, 1'b0, "R11 field 0 returns idle"); @(posedge clk); #1;
    wr(8'h18, 32'h7);

    // R12 pulse on match with idle high (R11 field 2)
    wr(8'h38, 32'h10); wr(8'h28, 32'h0E); wr(8'h24, 32'h880);
    @(negedge clk); pin(pwm, 1'b1, "R12 idle level high"); @(posedge clk); #1;
    wr(8'h24, 32'h8C1);
    @(negedge clk); pin(pwm, 1'b1, "R12 before match");
    @(posedge clk); @(negedge clk); pin(pwm, 1'b1, "R12 one step before match");
    @(posedge clk); @(negedge clk); pin(pwm, 1'b0, "R12 pulse on match");
    @(posedge clk); @(negedge clk); pin(pwm, 1'b1, "R12 pulse lasts one clock");
    @(posedge clk); #1;
    wr(8'h24, 32'h0);

    // R11 field 1 ignores match
    wr(8'h28, 32'h0E); wr(8'h24, 32'h1441); idle(4);
    @(negedge clk); pin(pwm, 1'b0, "R11 wrap-only ignores match"); @(posedge clk); #1;
    wr(8'h24, 32'h0); wr(8'h18, 32'h7);

    // R13 readback and fixed-zero offsets
    wr(8'h24, 32'hFFFF_FFFE); rd(8'h24, 32'h7FFE, "R13 ctrl 15 bits");
    wr(8'h24, 32'h0);
    wr(8'h20, 32'h5); rd(8'h20, 32'h5, "R13 wake mask");
    rd(8'h34, 32'h0, "R13 pending zero"); rd(8'h30, 32'h0, "R13 trigger zero");
    rd(8'h3C, 32'h0, "R13 capture zero");

    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule